// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block drives and observes 85 general-purpose pins. Software reaches it over a small synchronous register bus. The pins are grouped in three 32-bit banks: bank 0 holds pins 0..31 and bank 1 holds pins 32..63. Bank 2 holds pins 64..84, so only its low 21 bits exist. Each bank has nine register functions:

- a level readback;
- a direction register;
- write-only set and clear registers that alter the output latch;
- independent rising-edge and falling-edge detect enables;
- a sticky edge-detected status register;
- two registers of 2-bit alternate-function selectors.

Pin inputs are synchronized by two flops. The level readback and the edge detector both work on the synchronized value. An edge is found by comparing that value with its previous sample.

Each pin has a 2-bit selector. The selector can hand the pin's output to one of two peripheral signals in place of the GPIO latch. It also forwards the synchronized pin value to the chosen peripheral's input. A single interrupt line reports that at least one status bit is set.

Top module: `gpio_banked`

## Requirements
- R1: The address is {function[3:0], bank[1:0]}. The function codes are: level 0, direction 1, set 2, clear 3, rise enable 4, fall enable 5, status 6, alternate low 7, alternate high 8. A read presented in one cycle appears on `bus_rdata` after the next rising clock edge.
- R2: The level register returns the two-flop synchronized state of every pin in the bank, whatever the pin's direction. Writes to the level register are ignored. Unimplemented bits (bank 2 bits 31..21) read as 0.
- R3: Writing 1 to bit k of the set register drives the output latch of pin bank*32+k high. Writing 1 to that bit of the clear register drives it low. Zero bits leave the latch unchanged. Both registers read as 0. In GPIO mode `pin_out` shows the latch.
- R4: Bit k of the direction register drives `pin_oe` of that pin (1 means output). The register reads back as written. Bank 2 bits 31..21 ignore writes and read as 0.
- R5: With its rise-enable bit at 1, a 0 to 1 transition of a pin sets that pin's status bit. With the bit at 0, no rising edge sets it.
- R6: With its fall-enable bit at 1, a 1 to 0 transition sets the status bit. With both enables set, either transition sets it.
- R7: Status bits are write-one-to-clear, and zeros written leave them alone. An edge detected in the same cycle as the clear write keeps the bit set.
- R8: `irq` is the OR of all status bits.
- R9: Pin bank*32+j for j<16 has its selector at bits [2j+1:2j] of the alternate-low register. Pin bank*32+16+j has its selector at the same bits of the alternate-high register. Selector 01 drives `pin_out` from `af1_out`, 10 drives it from `af2_out`, and 00 or 11 drives it from the latch.
- R10: `af1_in` of a pin carries its synchronized value while the selector is 01, and is 0 otherwise. `af2_in` does the same for selector 10.
- R11: After reset every register is 0, so every pin is an input in GPIO mode with the latch low. `irq`, `pin_oe` and `pin_out` are then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address {function, bank} |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 85 | Asynchronous pin inputs |
| pin_out | output | 85 | Pin output values |
| pin_oe | output | 85 | Pin output enables |
| af1_out | input | 85 | Output signals of alternate function 1 |
| af2_out | input | 85 | Output signals of alternate function 2 |
| af1_in | output | 85 | Pin values forwarded to alternate function 1 |
| af2_in | output | 85 | Pin values forwarded to alternate function 2 |
| irq | output | 1 | OR of all edge-status bits |

## Verification
The bench drives two bit-complementary level patterns across all three banks. This exposes stuck or swapped bits and any leak into the unimplemented top of bank 2.

Three neighbouring pins get rise-only, fall-only and both enables. Raising and then lowering all three together shows that each edge type is gated by its own enable.

The status register is then cleared in three ways: with zeros, with a partial mask, and in the very cycle a fresh edge lands. This separates a correct write-one-to-clear from a plain write and from a clear that wins over a new edge.

The alternate-function checks give the latch, `af1_out` and `af2_out` different values on selectors 00, 01, 10 and 11. Only the right source can then produce the observed pin value.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int BANK_W    = 32;
    localparam int HALF_W    = BANK_W / 2;
    localparam int FN_BITS   = 4;
    localparam int BANK_BITS = 2;
    localparam int ADDR_W    = FN_BITS + BANK_BITS;

    typedef enum logic [FN_BITS-1:0] {
        FN_LEVEL  = 4'd0,
        FN_DIR    = 4'd1,
        FN_SET    = 4'd2,
        FN_CLR    = 4'd3,
        FN_RISE   = 4'd4,
        FN_FALL   = 4'd5,
        FN_STAT   = 4'd6,
        FN_ALT_LO = 4'd7,
        FN_ALT_HI = 4'd8
    } gpio_fn_e;

    typedef enum logic [1:0] {
        SEL_GPIO = 2'b00,
        SEL_ALT1 = 2'b01,
        SEL_ALT2 = 2'b10,
        SEL_RSVD = 2'b11
    } pin_sel_e;

    typedef struct packed {
        logic [FN_BITS-1:0]   fn;
        logic [BANK_BITS-1:0] bank;
    } reg_addr_t;

    function automatic logic wr_hit(input logic we, input reg_addr_t a,
                                    input int bank, input gpio_fn_e f);
        return we && (int'(a.bank) == bank) && (a.fn == f);
    endfunction

endpackage

// File: rtl/gpio_banked_sync.sv
module gpio_banked_sync #(
    parameter int W = 85
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_banked_regs.sv
module gpio_banked_regs
    import gpio_banked_pkg::*;
#(
    parameter int NUM_PINS = 85
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BANK_W-1:0]        bus_wdata,
    input  logic [NUM_PINS-1:0]      level,
    input  logic [NUM_PINS-1:0]      rise,
    input  logic [NUM_PINS-1:0]      fall,
    output logic [BANK_W-1:0]        bus_rdata,
    output logic [NUM_PINS-1:0]      latch_o,
    output logic [NUM_PINS-1:0]      dir_o,
    output logic [NUM_PINS-1:0][1:0] alt_o,
    output logic                     irq
);
    reg_addr_t a;
    assign a = reg_addr_t'(bus_addr);

    logic [NUM_PINS-1:0] ren_v;
    logic [NUM_PINS-1:0] fen_v;
    logic [NUM_PINS-1:0] stat_v;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int       B      = p / BANK_W;
        localparam int       K      = p % BANK_W;
        localparam int       J      = K % HALF_W;
        localparam gpio_fn_e ALT_FN = (K < HALF_W) ? FN_ALT_LO : FN_ALT_HI;

        logic       dir_r;
        logic       latch_r;
        logic       ren_r;
        logic       fen_r;
        logic       stat_r;
        logic [1:0] alt_r;
        logic       clr_hit;

        assign clr_hit = wr_hit(bus_we, a, B, FN_STAT) && bus_wdata[K];

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_r   <= 1'b0;
                latch_r <= 1'b0;
                ren_r   <= 1'b0;
                fen_r   <= 1'b0;
                stat_r  <= 1'b0;
                alt_r   <= SEL_GPIO;
            end else begin
                if (wr_hit(bus_we, a, B, FN_DIR))  dir_r <= bus_wdata[K];
                if (wr_hit(bus_we, a, B, FN_RISE)) ren_r <= bus_wdata[K];
                if (wr_hit(bus_we, a, B, FN_FALL)) fen_r <= bus_wdata[K];
                if (wr_hit(bus_we, a, B, ALT_FN))  alt_r <= bus_wdata[2*J +: 2];
                if (wr_hit(bus_we, a, B, FN_SET) && bus_wdata[K]) latch_r <= 1'b1;
                if (wr_hit(bus_we, a, B, FN_CLR) && bus_wdata[K]) latch_r <= 1'b0;
                stat_r <= (stat_r & ~clr_hit) | (rise[p] & ren_r) | (fall[p] & fen_r);
            end
        end

        assign dir_o[p]   = dir_r;
        assign latch_o[p] = latch_r;
        assign ren_v[p]   = ren_r;
        assign fen_v[p]   = fen_r;
        assign stat_v[p]  = stat_r;
        assign alt_o[p]   = alt_r;
    end

    logic [BANK_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        for (int k = 0; k < BANK_W; k++) begin
            if (int'(a.bank) * BANK_W + k < NUM_PINS) begin
                case (a.fn)
                    FN_LEVEL: rd_d[k] = level[int'(a.bank) * BANK_W + k];
                    FN_DIR:   rd_d[k] = dir_o[int'(a.bank) * BANK_W + k];
                    FN_RISE:  rd_d[k] = ren_v[int'(a.bank) * BANK_W + k];
                    FN_FALL:  rd_d[k] = fen_v[int'(a.bank) * BANK_W + k];
                    FN_STAT:  rd_d[k] = stat_v[int'(a.bank) * BANK_W + k];
                    default:  ;
                endcase
            end
        end
        for (int j = 0; j < HALF_W; j++) begin
            if (a.fn == FN_ALT_LO && int'(a.bank) * BANK_W + j < NUM_PINS)
                rd_d[2*j +: 2] = alt_o[int'(a.bank) * BANK_W + j];
            if (a.fn == FN_ALT_HI && int'(a.bank) * BANK_W + HALF_W + j < NUM_PINS)
                rd_d[2*j +: 2] = alt_o[int'(a.bank) * BANK_W + HALF_W + j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_d;
    end

    assign irq = |stat_v;

endmodule

// File: rtl/gpio_banked_pinmux.sv
module gpio_banked_pinmux
    import gpio_banked_pkg::*;
#(
    parameter int NUM_PINS = 85
) (
    input  logic [NUM_PINS-1:0]      latch,
    input  logic [NUM_PINS-1:0]      dir,
    input  logic [NUM_PINS-1:0][1:0] alt_sel,
    input  logic [NUM_PINS-1:0]      level,
    input  logic [NUM_PINS-1:0]      af1_out,
    input  logic [NUM_PINS-1:0]      af2_out,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic [NUM_PINS-1:0]      af1_in,
    output logic [NUM_PINS-1:0]      af2_in
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mux
        pin_sel_e sel;
        assign sel = pin_sel_e'(alt_sel[p]);

        always_comb begin
            case (sel)
                SEL_ALT1: pin_out[p] = af1_out[p];
                SEL_ALT2: pin_out[p] = af2_out[p];
                default:  pin_out[p] = latch[p];
            endcase
        end

        assign af1_in[p] = (sel == SEL_ALT1) & level[p];
        assign af2_in[p] = (sel == SEL_ALT2) & level[p];
        assign pin_oe[p] = dir[p];
    end

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
#(
    parameter int NUM_PINS = 85
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BANK_W-1:0]   bus_wdata,
    output logic [BANK_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] af1_out,
    input  logic [NUM_PINS-1:0] af2_out,
    output logic [NUM_PINS-1:0] af1_in,
    output logic [NUM_PINS-1:0] af2_in,
    output logic                irq
);
    logic [NUM_PINS-1:0]      level_w;
    logic [NUM_PINS-1:0]      rise_w;
    logic [NUM_PINS-1:0]      fall_w;
    logic [NUM_PINS-1:0]      latch_w;
    logic [NUM_PINS-1:0]      dir_w;
    logic [NUM_PINS-1:0][1:0] alt_w;

    gpio_banked_sync #(.W(NUM_PINS)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .level  (level_w),
        .rise   (rise_w),
        .fall   (fall_w)
    );

    gpio_banked_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .level     (level_w),
        .rise      (rise_w),
        .fall      (fall_w),
        .bus_rdata (bus_rdata),
        .latch_o   (latch_w),
        .dir_o     (dir_w),
        .alt_o     (alt_w),
        .irq       (irq)
    );

    gpio_banked_pinmux #(.NUM_PINS(NUM_PINS)) i_mux (
        .latch   (latch_w),
        .dir     (dir_w),
        .alt_sel (alt_w),
        .level   (level_w),
        .af1_out (af1_out),
        .af2_out (af2_out),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .af1_in  (af1_in),
        .af2_in  (af2_in)
    );

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
    import gpio_banked_pkg::*;
#(
    parameter int NUM_PINS = 85
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [BANK_W-1:0]   bus_wdata,
    input logic [BANK_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] latch_w,
    input logic [NUM_PINS-1:0] rise_w,
    input logic [NUM_PINS-1:0] fall_w
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int LAST_BANK = NUM_BANKS - 1;
    localparam int LAST_W    = NUM_PINS - LAST_BANK * BANK_W;

    reg_addr_t a;
    assign a = reg_addr_t'(bus_addr);

    logic wr_set, wr_clr, wr_stat;
    assign wr_set  = bus_we && (a.fn == FN_SET);
    assign wr_clr  = bus_we && (a.fn == FN_CLR);
    assign wr_stat = bus_we && (a.fn == FN_STAT);

    logic [NUM_PINS-1:0] wmask;
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
        assign wmask[p] = (int'(a.bank) == p / BANK_W) && bus_wdata[p % BANK_W];
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && !irq && latch_w == '0)); // R11

    AST_SET_LATCH: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((latch_w & $past(wmask)) == $past(wmask))); // R3

    AST_CLR_LATCH: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((latch_w & $past(wmask)) == '0)); // R3

    AST_STICKY_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_stat) |=> irq); // R7

    AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(rise_w | fall_w))); // R8

    AST_NO_BANK_DATA: assert property (@(posedge clk) disable iff (rst)
        (int'(a.bank) > LAST_BANK) |=> (bus_rdata == '0)); // R2

    if (LAST_W < BANK_W) begin : g_top_bits
        AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
            (int'(a.bank) == LAST_BANK) |=> (bus_rdata[BANK_W-1:LAST_W] == '0)); // R4
    end

endmodule

bind gpio_banked gpio_banked_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .latch_w   (latch_w),
    .rise_w    (rise_w),
    .fall_w    (fall_w)
);

// File: tb/test_gpio_banked.sv
`timescale 1ns/1ps
module test_gpio_banked;
    localparam int NP = 85;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, af1_in, af2_in;
    logic [NP-1:0] af1_out = '0;
    logic [NP-1:0] af2_out = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_req = 1'b0;
    logic        rsp_due = 1'b0;

    always #4 clk = ~clk;

    gpio_banked #(.NUM_PINS(NP)) i_gpio_banked (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .af1_out(af1_out), .af2_out(af2_out),
        .af1_in(af1_in), .af2_in(af2_in), .irq(irq)
    );

    function automatic logic [5:0] ra(input logic [3:0] f, input logic [1:0] b);
        return {f, b};
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // monitor: response captured at the posedge after the request
    always @(posedge clk) rsp_due <= rd_req;

    always @(negedge clk) begin
        if (rsp_due) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R1 unexpected read response actual=%h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [5:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = addr;
        rd_req = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wr(input logic [5:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr = addr;
        bus_wdata = data;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    localparam logic [84:0] PAT = {21'h1BCDEF, 32'h1234FEDC, 32'hA5C30F96};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk({31'd0, irq}, 32'd0, "R11 irq after reset");
        chk(pin_oe[31:0], 32'd0, "R11 pin_oe after reset");
        chk(pin_out[31:0], 32'd0, "R11 pin_out after reset");
        rd(ra(4'd1, 2'd0), 32'd0, "R11 direction bank0 reset");
        rd(ra(4'd6, 2'd1), 32'd0, "R11 status bank1 reset");
        rd(ra(4'd8, 2'd0), 32'd0, "R11 alt-high bank0 reset");

        // R2 level readback, two patterns
        pin_in = PAT;
        settle();
        rd(ra(4'd0, 2'd0), 32'hA5C30F96, "R2 level bank0 pattern");
        rd(ra(4'd0, 2'd1), 32'h1234FEDC, "R2 level bank1 pattern");
        rd(ra(4'd0, 2'd2), 32'h001BCDEF, "R2 level bank2 pattern");
        wr(ra(4'd0, 2'd0), 32'h0);
        rd(ra(4'd0, 2'd0), 32'hA5C30F96, "R2 level write ignored");
        pin_in = ~PAT;
        settle();
        rd(ra(4'd0, 2'd0), 32'h5A3CF069, "R2 level bank0 inverted");
        rd(ra(4'd0, 2'd2), 32'h00043210, "R2 level bank2 inverted top bits zero");
        rd(ra(4'd0, 2'd3), 32'h0, "R2 absent bank reads zero");

        // R4 direction
        wr(ra(4'd1, 2'd0), 32'hFFFFFFFF);
        wr(ra(4'd1, 2'd1), 32'h000000FF);
        wr(ra(4'd1, 2'd2), 32'hFFFFFFFF);
        rd(ra(4'd1, 2'd2), 32'h001FFFFF, "R4 direction bank2 unimplemented bits");
        rd(ra(4'd1, 2'd1), 32'h000000FF, "R4 direction bank1 readback");
        chk({31'd0, pin_oe[39]}, 32'd1, "R4 pin_oe[39]");
        chk({31'd0, pin_oe[40]}, 32'd0, "R4 pin_oe[40]");
        chk({11'd0, pin_oe[84:64]}, 32'h001FFFFF, "R4 pin_oe bank2");

        // R3 set / clear
        wr(ra(4'd2, 2'd0), 32'h000000F0);
        chk({24'd0, pin_out[7:0]}, 32'hF0, "R3 set bank0");
        wr(ra(4'd3, 2'd0), 32'h00000030);
        chk({24'd0, pin_out[7:0]}, 32'hC0, "R3 clear bank0");
        wr(ra(4'd2, 2'd0), 32'h0);
        wr(ra(4'd3, 2'd0), 32'h0);
        chk({24'd0, pin_out[7:0]}, 32'hC0, "R3 zero writes no effect");
        rd(ra(4'd2, 2'd0), 32'h0, "R3 set register reads zero");
        rd(ra(4'd3, 2'd0), 32'h0, "R3 clear register reads zero");
        wr(ra(4'd2, 2'd2), 32'hFFFFFFFF);
        chk({31'd0, pin_out[84]}, 32'd1, "R3 set pin84");
        wr(ra(4'd3, 2'd2), 32'h00100000);
        chk({30'd0, pin_out[84:83]}, 32'd1, "R3 clear pin84 keeps pin83");

        // R5 / R6 edge enables on pins 32,33,34
        pin_in = '0;
        settle();
        wr(ra(4'd4, 2'd1), 32'h5);
        wr(ra(4'd5, 2'd1), 32'h6);
        rd(ra(4'd4, 2'd1), 32'h5, "R5 rise enable readback");
        rd(ra(4'd6, 2'd1), 32'h0, "R5 no status before edges");
        pin_in[34:32] = 3'b111;
        settle();
        rd(ra(4'd6, 2'd1), 32'h5, "R5 rising edges set rise-enabled bits");
        chk({31'd0, irq}, 32'd1, "R8 irq set by status");
        wr(ra(4'd6, 2'd1), 32'h5);
        rd(ra(4'd6, 2'd1), 32'h0, "R7 write-one clears");
        chk({31'd0, irq}, 32'd0, "R8 irq low once clear");
        pin_in[34:32] = 3'b000;
        settle();
        rd(ra(4'd6, 2'd1), 32'h6, "R6 falling edges set fall-enabled bits");
        wr(ra(4'd6, 2'd1), 32'h0);
        rd(ra(4'd6, 2'd1), 32'h6, "R7 zero write keeps status");
        wr(ra(4'd6, 2'd1), 32'h2);
        rd(ra(4'd6, 2'd1), 32'h4, "R7 partial clear");

        // R7 edge in the same cycle as the clear
        @(negedge clk);
        pin_in[34] = 1'b1;
        @(negedge clk);
        wr(ra(4'd6, 2'd1), 32'h4);
        rd(ra(4'd6, 2'd1), 32'h4, "R7 simultaneous edge survives clear");
        wr(ra(4'd6, 2'd1), 32'h4);
        rd(ra(4'd6, 2'd1), 32'h0, "R7 later clear succeeds");
        chk({31'd0, irq}, 32'd0, "R8 irq low with no status");

        // R9 alternate output selection
        af1_out[5] = 1'b1;
        af2_out[20] = 1'b1;
        wr(ra(4'd7, 2'd0), 32'h00000400);
        wr(ra(4'd8, 2'd0), 32'h00000200);
        wr(ra(4'd7, 2'd2), 32'h00003000);
        wr(ra(4'd8, 2'd2), 32'hFFFFFFFF);
        rd(ra(4'd7, 2'd0), 32'h00000400, "R9 alt-low bank0 readback");
        rd(ra(4'd8, 2'd0), 32'h00000200, "R9 alt-high bank0 readback");
        rd(ra(4'd8, 2'd2), 32'h000003FF, "R9 alt-high bank2 only pins 80-84");
        chk({31'd0, pin_out[5]}, 32'd1, "R9 pin5 from af1_out");
        chk({31'd0, pin_out[20]}, 32'd1, "R9 pin20 from af2_out");
        chk({31'd0, pin_out[70]}, 32'd1, "R9 pin70 selector 11 uses latch");
        chk({31'd0, pin_out[6]}, 32'd1, "R9 pin6 selector 00 uses latch");
        af1_out[5] = 1'b0;
        af2_out[20] = 1'b0;
        af1_out[70] = 1'b0;
        #1;
        chk({30'd0, pin_out[20], pin_out[5]}, 32'd0, "R9 alt outputs follow peripheral");

        // R10 alternate input forwarding
        pin_in[5] = 1'b1;
        pin_in[20] = 1'b1;
        pin_in[70] = 1'b1;
        settle();
        chk({30'd0, af2_in[5], af1_in[5]}, 32'd1, "R10 pin5 to af1 only");
        chk({30'd0, af2_in[20], af1_in[20]}, 32'd2, "R10 pin20 to af2 only");
        chk({30'd0, af2_in[70], af1_in[70]}, 32'd0, "R10 pin70 selector 11 forwards nothing");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R1 missing read responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule